// File: doc/BRIEF.md
# Multicycle Load/Store Core with Precise Traps

A compact 32-bit processor core that executes each instruction as a sequence of one-cycle steps. All steps share one adder, one register file and one memory port. The supported instructions are add, word load, word store, branch-if-equal and absolute jump. A control state machine walks each instruction through its steps. Instruction fetch and data access use the same memory port, so the core never issues both in one cycle. Holding registers sit between the steps: the instruction word, the two operands, the adder result and the loaded data word.

During the operand-read step the core always computes a branch target, whatever the instruction turns out to be. If the instruction is a branch, the following step only has to compare the operands and, on equality, copy the saved target into the program counter.

Two faults are trapped: signed overflow of an add, and an instruction word the core does not recognise. A trap takes its own state-machine step. That step records the faulting instruction's address and a cause code, and sends execution to a fixed, parameterised handler address. The faulting instruction leaves no result behind.

Top module: `mc_core`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the program counter, the saved fault address and the cause register read 0, the fetch indicator is high and no memory write is issued.
- R2: In every fetch cycle the memory address equals the program counter, and the program counter advances by 4 at the end of that cycle.
- R3: An add (bits 31:26 = 0x00, bits 5:0 = 0x20) writes the sum of the registers selected by bits 25:21 and 20:16 into the register selected by bits 15:11. It takes 4 cycles.
- R4: A load (bits 31:26 = 0x23) reads the word at the address in the register selected by bits 25:21 plus the sign-extended bits 15:0. It writes that word into the register selected by bits 20:16 and takes 5 cycles.
- R5: A store (bits 31:26 = 0x2B) writes the register selected by bits 20:16 to that same computed address and takes 4 cycles. A memory write occurs only in the fourth cycle of a store.
- R6: A branch (bits 31:26 = 0x04) takes 3 cycles. When its two registers are equal, the next fetch is from the address of the branch + 4 + (sign-extended bits 15:0 shifted left by 2). Otherwise the next fetch is from the address of the branch + 4.
- R7: A jump (bits 31:26 = 0x02) takes 3 cycles. The next fetch is from bits 31:28 of the address of the jump + 4, followed by bits 25:0, followed by two zero bits.
- R8: Register 0 reads as zero, including after a load that targets it.
- R9: An add whose signed result overflows does not write its destination register. In its fourth cycle it sets cause to 1, sets the saved fault address to the address of the add, and sets the program counter to the handler address. The next fetch follows.
- R10: An unrecognised opcode, or opcode 0x00 with a function field other than 0x20, leaves registers and memory untouched. Its third cycle sets cause to 0, sets the saved fault address to the instruction's address, and sets the program counter to the handler address.
- R11: The saved fault address and the cause register change only in a trap cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 32 | Byte address of the shared memory port |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Write strobe, one cycle per store |
| mem_rdata | input | 32 | Read data, valid in the same cycle as the address |
| pc | output | 32 | Current program counter |
| epc | output | 32 | Address of the last faulting instruction |
| cause | output | 32 | Code of the last trap: 1 overflow, 0 unrecognised |
| fetch | output | 1 | High during the fetch step of each instruction |

## Verification
The bound checker checks on every cycle:
- the fetch address and the +4 step of the program counter;
- that writes appear only in the store step;
- the exact program counter, saved address and cause value after each kind of trap;
- that the saved address and cause hold still outside trap steps.

Other behaviour is visible only through whole programs run from the bench's memory model:
- whether an add suppresses its register write when it overflows;
- that register 0 ignores a load;
- branch and jump target arithmetic;
- the per-instruction cycle counts, measured between fetch pulses.

Random operand pairs feed the add path and its overflow detection. Directed runs add the signed overflow boundaries and a control-flow program.

// File: rtl/mc_pkg.sv
package mc_pkg;

   typedef enum logic [3:0] {
      ST_FETCH, ST_DECODE, ST_EX_ADD, ST_EX_ADDR, ST_EX_BR, ST_EX_JMP,
      ST_WB_ALU, ST_MEM_RD, ST_MEM_WR, ST_WB_MEM, ST_TRAP_OVF, ST_TRAP_UND
   } state_t;

   localparam logic [5:0] OP_RTYPE = 6'h00;
   localparam logic [5:0] OP_LOAD  = 6'h23;
   localparam logic [5:0] OP_STORE = 6'h2B;
   localparam logic [5:0] OP_BEQ   = 6'h04;
   localparam logic [5:0] OP_JUMP  = 6'h02;
   localparam logic [5:0] FN_ADD   = 6'h20;

   localparam int CAUSE_UNDEF = 0;
   localparam int CAUSE_OVF   = 1;

   typedef enum logic       {ASEL_PC, ASEL_REG} asel_t;
   typedef enum logic [1:0] {BSEL_REG, BSEL_FOUR, BSEL_IMM, BSEL_BRIMM} bsel_t;
   // value 3 selects the trap vector
   typedef enum logic [1:0] {PCS_ALU, PCS_SAVED, PCS_JUMP, PCS_VECTOR} pcsel_t;

   typedef struct packed {
      logic   pc_we;
      pcsel_t pc_src;
      logic   ir_we;
      logic   mdr_we;
      logic   ab_we;
      logic   out_we;
      asel_t  alu_a;
      bsel_t  alu_b;
      logic   rf_we;
      logic   rf_from_mem;
      logic   rf_dst_rt;
      logic   mem_we;
      logic   mem_from_out;
      logic   trap_we;
      logic   trap_ovf;
   } ctrl_t;

endpackage

// File: rtl/mc_alu.sv
module mc_alu #(
   parameter int W              = 32,
   parameter bit OVF_FROM_CARRY = 1'b0
) (
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   output logic [W-1:0] sum,
   output logic         ovf
);
   logic [W:0] low_part;
   logic       carry_top;

   assign sum = op_a + op_b;

   generate
      if (OVF_FROM_CARRY) begin : g_carry
         // overflow = carry into MSB xor carry out of MSB
         assign low_part  = {1'b0, 1'b0, op_a[W-2:0]} + {1'b0, 1'b0, op_b[W-2:0]};
         assign carry_top = (op_a[W-1] & op_b[W-1]) |
                            ((op_a[W-1] ^ op_b[W-1]) & low_part[W-1]);
         assign ovf       = low_part[W-1] ^ carry_top;
      end else begin : g_sign
         assign low_part  = '0;
         assign carry_top = 1'b0;
         assign ovf = (op_a[W-1] == op_b[W-1]) && (sum[W-1] != op_a[W-1]);
      end
   endgenerate
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
   parameter int W        = 32,
   parameter int NREGS    = 32,
   parameter bit ZERO_REG = 1'b1,
   localparam int AW      = $clog2(NREGS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] ra1,
   input  logic [AW-1:0] ra2,
   output logic [W-1:0]  rd1,
   output logic [W-1:0]  rd2,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [W-1:0]  wd
);
   logic [NREGS*W-1:0] flat;

   generate
      for (genvar i = 0; i < NREGS; i++) begin : g_reg
         if (i == 0 && ZERO_REG) begin : g_zero
            assign flat[i*W +: W] = '0;
         end else begin : g_flop
            logic [W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                         q <= '0;
               else if (we && wa == AW'(i))        q <= wd;
            end
            assign flat[i*W +: W] = q;
         end
      end
   endgenerate

   assign rd1 = flat[ra1*W +: W];
   assign rd2 = flat[ra2*W +: W];
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
   import mc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [5:0] opcode,
   input  logic [5:0] funct,
   input  logic       a_eq_b,
   input  logic       add_ovf,
   output state_t     state,
   output ctrl_t      ctl
);
   state_t nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_FETCH;
      else        state <= nxt;
   end

   always_comb begin
      nxt = ST_FETCH;
      unique case (state)
         ST_FETCH:  nxt = ST_DECODE;
         ST_DECODE: begin
            case (opcode)
               OP_RTYPE:          nxt = (funct == FN_ADD) ? ST_EX_ADD : ST_TRAP_UND;
               OP_LOAD, OP_STORE: nxt = ST_EX_ADDR;
               OP_BEQ:            nxt = ST_EX_BR;
               OP_JUMP:           nxt = ST_EX_JMP;
               default:           nxt = ST_TRAP_UND;
            endcase
         end
         ST_EX_ADD:  nxt = add_ovf ? ST_TRAP_OVF : ST_WB_ALU;
         ST_EX_ADDR: nxt = (opcode == OP_LOAD) ? ST_MEM_RD : ST_MEM_WR;
         ST_MEM_RD:  nxt = ST_WB_MEM;
         default:    nxt = ST_FETCH;
      endcase
   end

   always_comb begin
      ctl = '0;
      unique case (state)
         ST_FETCH: begin
            ctl.ir_we  = 1'b1;
            ctl.pc_we  = 1'b1;
            ctl.pc_src = PCS_ALU;
            ctl.alu_a  = ASEL_PC;
            ctl.alu_b  = BSEL_FOUR;
         end
         ST_DECODE: begin
            ctl.ab_we  = 1'b1;
            ctl.out_we = 1'b1;
            ctl.alu_a  = ASEL_PC;
            ctl.alu_b  = BSEL_BRIMM;
         end
         ST_EX_ADD: begin
            ctl.out_we = 1'b1;
            ctl.alu_a  = ASEL_REG;
            ctl.alu_b  = BSEL_REG;
         end
         ST_EX_ADDR: begin
            ctl.out_we = 1'b1;
            ctl.alu_a  = ASEL_REG;
            ctl.alu_b  = BSEL_IMM;
         end
         ST_EX_BR: begin
            ctl.pc_we  = a_eq_b;
            ctl.pc_src = PCS_SAVED;
         end
         ST_EX_JMP: begin
            ctl.pc_we  = 1'b1;
            ctl.pc_src = PCS_JUMP;
         end
         ST_WB_ALU: ctl.rf_we = 1'b1;
         ST_MEM_RD: begin
            ctl.mem_from_out = 1'b1;
            ctl.mdr_we       = 1'b1;
         end
         ST_MEM_WR: begin
            ctl.mem_from_out = 1'b1;
            ctl.mem_we       = 1'b1;
         end
         ST_WB_MEM: begin
            ctl.rf_we       = 1'b1;
            ctl.rf_from_mem = 1'b1;
            ctl.rf_dst_rt   = 1'b1;
         end
         ST_TRAP_OVF, ST_TRAP_UND: begin
            ctl.trap_we  = 1'b1;
            ctl.trap_ovf = (state == ST_TRAP_OVF);
            ctl.pc_we    = 1'b1;
            ctl.pc_src   = PCS_VECTOR;
         end
         default: ctl = '0;
      endcase
   end
endmodule

// File: rtl/mc_core.sv
module mc_core
   import mc_pkg::*;
#(
   parameter int          XLEN           = 32,
   parameter int          NREGS          = 32,
   parameter logic [31:0] TRAP_VECTOR    = 32'hC000_0000,
   parameter bit          ZERO_REG       = 1'b1,
   parameter bit          OVF_FROM_CARRY = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [XLEN-1:0] mem_addr,
   output logic [XLEN-1:0] mem_wdata,
   output logic            mem_we,
   input  logic [XLEN-1:0] mem_rdata,
   output logic [XLEN-1:0] pc,
   output logic [XLEN-1:0] epc,
   output logic [XLEN-1:0] cause,
   output logic            fetch
);
   localparam int AW = $clog2(NREGS);

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("mc_core: the instruction encoding needs XLEN of 32");
      end
      if (NREGS < 2 || NREGS > 32 || (1 << AW) != NREGS) begin : g_bad_nregs
         $error("mc_core: NREGS must be a power of two from 2 to 32");
      end
      if (TRAP_VECTOR[1:0] != 2'b00) begin : g_bad_vec
         $error("mc_core: TRAP_VECTOR must be word aligned");
      end
   endgenerate

   state_t          state_q;
   ctrl_t           ctl;
   logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, out_q, epc_q, cause_q;
   logic [XLEN-1:0] rd1, rd2, alu_a, alu_b, alu_sum, imm_sx, pc_next, wb_data;
   logic            alu_ovf;
   logic [4:0]      rs_f, rt_f, rd_f;
   logic [AW-1:0]   wb_addr;

   assign rs_f   = ir_q[25:21];
   assign rt_f   = ir_q[20:16];
   assign rd_f   = ir_q[15:11];
   assign imm_sx = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};

   mc_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .opcode (ir_q[31:26]),
      .funct  (ir_q[5:0]),
      .a_eq_b (a_q == b_q),
      .add_ovf(alu_ovf),
      .state  (state_q),
      .ctl    (ctl)
   );

   always_comb begin
      alu_a = (ctl.alu_a == ASEL_PC) ? pc_q : a_q;
      unique case (ctl.alu_b)
         BSEL_REG:   alu_b = b_q;
         BSEL_FOUR:  alu_b = XLEN'(4);
         BSEL_IMM:   alu_b = imm_sx;
         BSEL_BRIMM: alu_b = {imm_sx[XLEN-3:0], 2'b00};
         default:    alu_b = '0;
      endcase
   end

   mc_alu #(.W(XLEN), .OVF_FROM_CARRY(OVF_FROM_CARRY)) u_alu (
      .op_a(alu_a),
      .op_b(alu_b),
      .sum (alu_sum),
      .ovf (alu_ovf)
   );

   always_comb begin
      unique case (ctl.pc_src)
         PCS_ALU:    pc_next = alu_sum;
         PCS_SAVED:  pc_next = out_q;
         PCS_JUMP:   pc_next = {pc_q[XLEN-1:XLEN-4], ir_q[25:0], 2'b00};
         PCS_VECTOR: pc_next = TRAP_VECTOR;
         default:    pc_next = pc_q;
      endcase
   end

   assign wb_addr = ctl.rf_dst_rt ? rt_f[AW-1:0] : rd_f[AW-1:0];
   assign wb_data = ctl.rf_from_mem ? mdr_q : out_q;

   mc_regfile #(.W(XLEN), .NREGS(NREGS), .ZERO_REG(ZERO_REG)) u_rf (
      .clk  (clk),
      .rst_n(rst_n),
      .ra1  (rs_f[AW-1:0]),
      .ra2  (rt_f[AW-1:0]),
      .rd1  (rd1),
      .rd2  (rd2),
      .we   (ctl.rf_we),
      .wa   (wb_addr),
      .wd   (wb_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q    <= '0;
         ir_q    <= '0;
         mdr_q   <= '0;
         a_q     <= '0;
         b_q     <= '0;
         out_q   <= '0;
         epc_q   <= '0;
         cause_q <= '0;
      end else begin
         if (ctl.pc_we)  pc_q  <= pc_next;
         if (ctl.ir_we)  ir_q  <= mem_rdata;
         if (ctl.mdr_we) mdr_q <= mem_rdata;
         if (ctl.ab_we) begin
            a_q <= rd1;
            b_q <= rd2;
         end
         if (ctl.out_we) out_q <= alu_sum;
         if (ctl.trap_we) begin
            epc_q   <= pc_q - XLEN'(4);
            cause_q <= ctl.trap_ovf ? XLEN'(CAUSE_OVF) : XLEN'(CAUSE_UNDEF);
         end
      end
   end

   assign mem_addr  = ctl.mem_from_out ? out_q : pc_q;
   assign mem_wdata = b_q;
   assign mem_we    = ctl.mem_we;
   assign pc        = pc_q;
   assign epc       = epc_q;
   assign cause     = cause_q;
   assign fetch     = (state_q == ST_FETCH);
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
   import mc_pkg::*;
#(
   parameter int          XLEN        = 32,
   parameter logic [31:0] TRAP_VECTOR = 32'hC000_0000
) (
   input logic            clk,
   input logic            rst_n,
   input state_t          state,
   input logic [XLEN-1:0] pc,
   input logic [XLEN-1:0] epc,
   input logic [XLEN-1:0] cause,
   input logic [XLEN-1:0] mem_addr,
   input logic            mem_we
);
   AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_FETCH |-> mem_addr == pc); // R2

   AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_FETCH |=> pc == $past(pc) + XLEN'(4)); // R2

   AST_WRITE_IN_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> state == ST_MEM_WR); // R5

   AST_TRAP_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_TRAP_OVF |=> (pc == TRAP_VECTOR && cause == XLEN'(1)
                                && epc == $past(pc) - XLEN'(4))); // R9

   AST_TRAP_UND: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_TRAP_UND |=> (pc == TRAP_VECTOR && cause == XLEN'(0)
                                && epc == $past(pc) - XLEN'(4))); // R10

   AST_TRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_TRAP_OVF && state != ST_TRAP_UND) |=>
         ($stable(epc) && $stable(cause))); // R11
endmodule

bind mc_core mc_core_chk #(.XLEN(XLEN), .TRAP_VECTOR(TRAP_VECTOR)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .state   (state_q),
   .pc      (pc),
   .epc     (epc),
   .cause   (cause),
   .mem_addr(mem_addr),
   .mem_we  (mem_we)
);

// File: tb/tb_mc_core.sv
`timescale 1ns/1ps
module tb_mc_core;
   localparam logic [31:0] VEC  = 32'hC000_0300;
   localparam logic [31:0] SENT = 32'hDEAD_BEEF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] mem_addr, mem_wdata, mem_rdata, pc, epc, cause;
   logic        mem_we, fetch;
   logic [31:0] mem [0:255];

   int checks = 0, errors = 0, nf = 0, cyc = 0;
   int fcyc [0:31];
   logic [31:0] fpc [0:31];

   always #10 clk = ~clk;

   mc_core #(.TRAP_VECTOR(VEC)) dut (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_we(mem_we), .mem_rdata(mem_rdata), .pc(pc), .epc(epc),
      .cause(cause), .fetch(fetch)
   );

   assign mem_rdata = mem[mem_addr[9:2]];
   always @(posedge clk) if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;

   always @(negedge clk) if (rst_n) begin
      cyc = cyc + 1;
      if (fetch) begin
         if (nf < 32) begin
            fcyc[nf] = cyc;
            fpc[nf]  = pc;
         end
         nf = nf + 1;
      end
   end

   function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                         input logic [4:0] rt, input logic [15:0] imm);
      return {op, rs, rt, imm};
   endfunction
   function automatic logic [31:0] enc_add(input logic [4:0] rs, input logic [4:0] rt,
                                           input logic [4:0] rd);
      return {6'h00, rs, rt, rd, 5'd0, 6'h20};
   endfunction
   function automatic logic exp_ovf(input logic [31:0] x, input logic [31:0] y);
      logic [31:0] s = x + y;
      return (x[31] == y[31]) && (s[31] != x[31]);
   endfunction
   function automatic int ilen(input int i);
      return fcyc[i+1] - fcyc[i];
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic prep();
      @(negedge clk);
      rst_n = 1'b0;
      for (int i = 0; i < 256; i++) mem[i] = '0;
      mem[130] = SENT; mem[131] = SENT;
      for (int i = 132; i < 136; i++) mem[i] = SENT;
      // handler at VEC: store r3 to 0x20C, then spin
      mem[192] = enc_i(6'h2B, 5'd0, 5'd3, 16'h020C);
      mem[193] = enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF);
   endtask

   task automatic start();
      nf = 0; cyc = 0;
      @(posedge clk); @(posedge clk); #2 rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R1 pc", pc, 32'h0);
      chk("R1 epc/cause", epc | cause, 32'h0);
      chk("R1 fetch/we", {30'd0, fetch, mem_we}, 32'h2);
   endtask

   task automatic run_add(input logic [31:0] x, input logic [31:0] y);
      logic [31:0] s;
      logic        ov;
      s  = x + y;
      ov = exp_ovf(x, y);
      prep();
      mem[0] = enc_i(6'h23, 5'd0, 5'd1, 16'h0200);
      mem[1] = enc_i(6'h23, 5'd0, 5'd2, 16'h0204);
      mem[2] = enc_add(5'd1, 5'd2, 5'd3);
      mem[3] = enc_i(6'h2B, 5'd0, 5'd3, 16'h0208);
      mem[4] = enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF);
      mem[128] = x; mem[129] = y;
      start();
      repeat (60) @(negedge clk);
      #1;
      chk("R4 lw length", ilen(0), 5);
      if (!ov) begin
         chk("R3 sum stored", mem[130], s);
         chk("R3 add length", ilen(2), 4);
         chk("R5 sw length", ilen(3), 4);
         chk("R11 no trap epc", epc, 32'h0);
         chk("R6 loop fetch", fpc[5], 32'h10);
      end else begin
         chk("R9 store skipped", mem[130], SENT);
         chk("R9 rd unwritten", mem[131], 32'h0);
         chk("R9 trap length", ilen(2), 4);
         chk("R9 vector fetch", fpc[3], VEC);
         chk("R9 epc", epc, 32'h8);
         chk("R9 cause", cause, 32'h1);
      end
   endtask

   task automatic run_flow();
      prep();
      mem[0]  = enc_i(6'h23, 5'd0, 5'd0, 16'h0200);
      mem[1]  = enc_i(6'h2B, 5'd0, 5'd0, 16'h0210);
      mem[2]  = enc_i(6'h23, 5'd0, 5'd1, 16'h0200);
      mem[3]  = enc_i(6'h04, 5'd1, 5'd0, 16'h0004);
      mem[4]  = {6'h02, 26'd7};
      mem[5]  = enc_i(6'h2B, 5'd0, 5'd1, 16'h0214);
      mem[6]  = enc_i(6'h2B, 5'd0, 5'd1, 16'h0214);
      mem[7]  = enc_i(6'h2B, 5'd0, 5'd1, 16'h0218);
      mem[8]  = enc_i(6'h04, 5'd1, 5'd1, 16'h0002);
      mem[9]  = enc_i(6'h2B, 5'd0, 5'd1, 16'h021C);
      mem[10] = enc_i(6'h2B, 5'd0, 5'd1, 16'h021C);
      mem[11] = {6'h16, 5'd1, 5'd1, 5'd1, 5'd0, 6'h10};
      mem[12] = enc_i(6'h2B, 5'd0, 5'd1, 16'h021C);
      mem[128] = 32'h0000_1234;
      start();
      repeat (70) @(negedge clk);
      #1;
      chk("R8 r0 after load", mem[132], 32'h0);
      chk("R5 sw length", ilen(1), 4);
      chk("R6 not-taken length", ilen(3), 3);
      chk("R6 not-taken next", fpc[4], 32'h10);
      chk("R7 jump length", ilen(4), 3);
      chk("R7 jump target", fpc[5], 32'h1C);
      chk("R7 skipped store", mem[133], SENT);
      chk("R7 landing store", mem[134], 32'h1234);
      chk("R6 taken length", ilen(6), 3);
      chk("R6 taken target", fpc[7], 32'h2C);
      chk("R6 skipped store", mem[135], SENT);
      chk("R10 undef length", ilen(7), 3);
      chk("R10 vector fetch", fpc[8], VEC);
      chk("R10 epc", epc, 32'h2C);
      chk("R10 cause", cause, 32'h0);
      chk("R10 regs intact", mem[131], 32'h0);
   endtask

   task automatic run_badfunct();
      prep();
      mem[0] = {6'h00, 5'd0, 5'd0, 5'd3, 5'd0, 6'h22};
      start();
      repeat (20) @(negedge clk);
      #1;
      chk("R10 funct trap epc", epc, 32'h0);
      chk("R10 funct vector", fpc[1], VEC);
      chk("R10 funct length", ilen(0), 3);
   endtask

   initial begin
      void'($urandom(32'd2024));
      run_add(32'h0000_0005, 32'h0000_0007);
      run_add(32'h7FFF_FFFF, 32'h0000_0001);
      run_add(32'h8000_0000, 32'hFFFF_FFFF);
      run_add(32'h7FFF_FFFF, 32'h8000_0000);
      run_add(32'hFFFF_FFFF, 32'h0000_0001);
      for (int k = 0; k < 8; k++) run_add($urandom, $urandom);
      run_flow();
      run_badfunct();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule